// File: doc/BRIEF.md
# Predicated Tree Reduction Sequencer

This block sums the active elements of a short vector with a pairwise tree. One tree level is done per clock cycle. A start strobe captures the vector length, the element data and a lane predicate into local registers. The block then walks the levels with a half-step of 1, 2, 4 and so on. At each level, every entry whose position is a multiple of the step is paired with the entry one half-step further on.

No element ever changes lanes. The block works on its own copy of the predicate and keeps a per-entry lookup index, which starts as the identity. Three cases arise at each pair:
- If both sides of a pair are active, the partner's element is added in place into the element that the current entry's index selects.
- If only the partner is active, the current entry takes over the partner's index, and no data moves.
- In every case, the partner's validity is ORed into the current entry's working predicate bit.

When the tree finishes, a one-cycle done pulse is raised. The total sits in the element that index entry 0 selects, and working predicate bit 0 tells whether any lane was active. The whole sequence depends only on the length and the starting predicate, so the intermediate state can be rebuilt from those two values.

Top module: `tree_reduce_seq`

## Requirements
- R1: After reset, done is 0, pred_out is all zeros, data_out is all zeros and idx_out is the identity (lane k holds k).
- R2: A start accepted while idle copies data_in and pred_in into the working state and sets the index table to the identity. With a length of 0 or 1, no level changes anything, so the outputs equal the captured inputs.
- R3: After done, if any lane below the length had its predicate bit set, pred_out bit 0 is 1. The element at data_out lane idx_out[0] then equals the sum of the active elements.
- R4: An element whose lane is at or above the length, or whose predicate bit was clear, leaves the reduction with its captured value unchanged.
- R5: At each level with half-step h, entry i (a multiple of 2h, below the length) has a valid partner i+h only if i+h is below the length and its working bit is set. When entry i itself is inactive and the partner is valid, entry i takes the partner's index. Index entries never point below their own lane.
- R6: After each pair, the partner's validity is ORed into the working bit of entry i. Working bits are never cleared during a reduction.
- R7: done is high for exactly one cycle, max(1, ceil(log2(length))) clock edges after the edge that accepted start.
- R8: start is ignored while a reduction is in progress. The outputs reflect only the inputs captured at the accepting edge.
- R9: A length above 16 is treated as 16.
- R10: Additions wrap modulo 2^64.

Bit layout: lane k of data_in and data_out sits at bits [64k+63:64k]. Lane k of idx_out sits at bits [4k+3:4k]. Bit k of pred_in and pred_out belongs to lane k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction when idle |
| vl | input | 5 | Vector length, clamped to 16 |
| pred_in | input | 16 | Lane predicate |
| data_in | input | 1024 | Sixteen 64-bit elements |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | 1024 | Element array in place |
| pred_out | output | 16 | Working predicate |
| idx_out | output | 64 | Index redirection table |

## Verification
Two functions can meet on one edge: a new start strobe, and a tree level being applied, including the final level that raises done. The bench provokes this by pulsing start with different length, predicate and data on the first edge after acceptance. For one-level lengths, that edge is also the final one. The run is judged by comparing every output lane, the done timing and the total against a model built from the originally captured inputs alone.

// File: rtl/tree_reduce_seq.sv
module tree_reduce_seq #(
  parameter int N = 16,
  parameter int W = 64,
  localparam int LW = $clog2(N),
  localparam int VW = LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VW-1:0]   vl,
  input  logic [N-1:0]    pred_in,
  input  logic [N*W-1:0]  data_in,
  output logic            done,
  output logic [N*W-1:0]  data_out,
  output logic [N-1:0]    pred_out,
  output logic [N*LW-1:0] idx_out
);

  logic [W-1:0]  elem [N];
  logic [LW-1:0] idx  [N];
  logic [LW-1:0] psrc [N];
  logic [N-1:0]  wp, pair, pv;
  logic [VW-1:0] vlq;
  logic [VW:0]   half, half2;
  logic          busy, done_q;

  assign half2 = half << 1;
  assign done = done_q;
  assign pred_out = wp;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [VW:0] j;
    assign j = (VW+1)'(i) + half;
    assign pair[i] = busy && ((VW+1)'(i) < {1'b0, vlq}) &&
                     (((VW+1)'(i) & (half2 - 1'b1)) == '0);
    assign pv[i] = (j < {1'b0, vlq}) && wp[j[LW-1:0]];
    assign psrc[i] = idx[j[LW-1:0]];
    assign data_out[i*W +: W] = elem[i];
    assign idx_out[i*LW +: LW] = idx[i];

    AST_IDX_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      idx[i] >= LW'(i)); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        elem[k] <= '0;
        idx[k]  <= LW'(k);
      end
      wp     <= '0;
      vlq    <= '0;
      half   <= '0;
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          for (int k = 0; k < N; k++) begin
            elem[k] <= data_in[k*W +: W];
            idx[k]  <= LW'(k);
          end
          wp   <= pred_in;
          vlq  <= (vl > VW'(N)) ? VW'(N) : vl;
          half <= (VW+1)'(1);
          busy <= 1'b1;
        end
      end else begin
        for (int k = 0; k < N; k++) begin
          if (pair[k]) begin
            if (wp[k] && pv[k])
              elem[idx[k]] <= elem[idx[k]] + elem[psrc[k]];
            else if (pv[k])
              idx[k] <= psrc[k];
            if (pv[k])
              wp[k] <= 1'b1;
          end
        end
        half <= half2;
        if (half2 >= {1'b0, vlq}) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_PRED_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((wp & $past(wp)) == $past(wp))); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vlq)); // R8
  AST_VL_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vlq <= VW'(N))); // R9
  AST_HALF_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(half) == 1)); // R5

endmodule

// File: tb/test_tree_reduce_seq.sv
`timescale 1ns/1ps
module test_tree_reduce_seq;
  localparam int N = 16, W = 64, LW = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] vl = 0;
  logic [N-1:0] pred_in = 0;
  logic [N*W-1:0] data_in = 0;
  logic done;
  logic [N*W-1:0] data_out;
  logic [N-1:0] pred_out;
  logic [N*LW-1:0] idx_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [W-1:0]  o_data [N];
  logic [W-1:0]  m_data [N];
  logic [LW-1:0] m_idx  [N];
  logic [N-1:0]  o_pred, m_wp;

  tree_reduce_seq i_tree_reduce_seq (.clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .pred_in(pred_in), .data_in(data_in), .done(done), .data_out(data_out),
    .pred_out(pred_out), .idx_out(idx_out));

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(int v);
    int h;
    for (int k = 0; k < N; k++) begin
      m_data[k] = o_data[k];
      m_idx[k] = LW'(k);
    end
    m_wp = o_pred;
    h = 1;
    while (h < v) begin
      for (int i = 0; i < v; i += 2*h) begin
        int j;
        bit p;
        j = i + h;
        p = 0;
        if (j < v) p = m_wp[j];
        if (m_wp[i] && p) m_data[m_idx[i]] = m_data[m_idx[i]] + m_data[m_idx[j]];
        else if (p) m_idx[i] = m_idx[j];
        if (p) m_wp[i] = 1'b1;
      end
      h *= 2;
    end
  endtask

  task automatic run(int vin, logic [N-1:0] p, string tag, bit poke);
    int v, lat, cnt, h;
    logic [W-1:0] sum;
    logic [N*W-1:0] exp_d;
    logic [N*LW-1:0] exp_i;
    bit any;
    v = (vin > N) ? N : vin;
    o_pred = p;
    for (int k = 0; k < N; k++) data_in[k*W +: W] = o_data[k];
    pred_in = p;
    vl = 5'(vin);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      start = 1;
      vl = 5'(N - 1);
      pred_in = ~p;
      data_in = ~data_in;
    end
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      start = 0;
      cnt++;
    end
    model(v);
    lat = 0; h = 1;
    while (h < v) begin lat++; h *= 2; end
    if (lat == 0) lat = 1;
    chk(done && cnt == lat, {"R7 latency ", tag}, 1024'(cnt), 1024'(lat));
    for (int k = 0; k < N; k++) begin
      exp_d[k*W +: W] = m_data[k];
      exp_i[k*LW +: LW] = m_idx[k];
    end
    chk(data_out == exp_d, {"R3 data ", tag}, data_out, exp_d);
    chk(idx_out == exp_i, {"R5 index ", tag}, idx_out, exp_i);
    chk(pred_out == m_wp, {"R6 pred ", tag}, pred_out, m_wp);
    any = 0; sum = 0;
    for (int k = 0; k < v; k++) if (p[k]) begin any = 1; sum += o_data[k]; end
    if (any) begin
      logic [W-1:0] got;
      got = data_out[idx_out[LW-1:0]*W +: W];
      chk(pred_out[0] && got == sum, {"R3 total ", tag}, got, sum);
    end
    for (int k = 0; k < N; k++)
      if (k >= v || !p[k])
        chk(data_out[k*W +: W] == o_data[k], {"R4 untouched ", tag},
            data_out[k*W +: W], o_data[k]);
    @(negedge clk);
    chk(!done, {"R7 pulse ", tag}, 1024'(done), 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*LW-1:0] ident;
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < N; k++) ident[k*LW +: LW] = LW'(k);
    #12 rst_n = 1;
    @(negedge clk);
    chk(!done, "R1 done", 1024'(done), 0);
    chk(pred_out == 0, "R1 pred", 1024'(pred_out), 0);
    chk(data_out == 0, "R1 data", data_out, 0);
    chk(idx_out == ident, "R1 index", idx_out, ident);

    for (int k = 0; k < N; k++) o_data[k] = {$urandom, $urandom};
    run(0, 16'hA5C3, "R2 vl0", 0);
    chk(pred_out == 16'hA5C3 && idx_out == ident, "R2 copy", 1024'(pred_out), 1024'(16'hA5C3));
    run(1, 16'hFFFF, "R2 vl1", 0);
    run(16, 16'hFFFF, "full", 0);
    run(16, 16'h0000, "none", 0);
    run(16, 16'h8000, "last", 0);
    run(5, 16'h0016, "odd", 0);
    run(20, 16'hF0F1, "R9 clamp", 0);
    for (int k = 0; k < N; k++) o_data[k] = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(k);
    run(16, 16'hFFFF, "R10 wrap", 0);
    run(2, 16'h0003, "R8 poke2", 1);
    run(9, 16'h01A2, "R8 poke9", 1);
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < N; k++) o_data[k] = {$urandom, $urandom};
      run($urandom_range(20, 0), 16'($urandom), "random", t % 5 == 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule